// File: doc/BRIEF.md
# ADC Sample Requantizer

This block accepts raw converter sample words and delivers signed two's-complement samples sized for a downstream multiplier. A per-sample format select states how the incoming word is coded: bipolar offset binary, bipolar two's complement, or unipolar straight binary. The converted value is then narrowed to a smaller output width. The narrowing can truncate, round to nearest, or add a pseudo-random dither before the low bits are dropped.

Bipolar results are held to a symmetric full scale. The single most negative code is treated as an over-range event, as is any narrowing result that lands outside the symmetric range. Both are clamped and reported on a clip flag that travels with the sample. Samples enter and leave as valid-qualified words, and every sample takes exactly two clock cycles to pass through.

Top module: `adc_requant`

## Requirements
- R1: With `in_fmt` = 0 (offset binary), the input is read as `in_data` minus 2^(IN_W-1), which is the same as flipping only the top bit. Code 2^(IN_W-1) maps to zero.
- R2: With `in_fmt` = 1 or 3, the input is already signed two's complement and passes through as its signed value.
- R3: With `in_fmt` = 2 (unipolar), the input is taken as a non-negative value one bit wider than the input, with a zero sign bit in front.
- R4: The output drops IN_W-OUT_W low bits in the bipolar formats and IN_W+1-OUT_W low bits in unipolar. With `red_mode` = 0 the result is the floor of the value divided by 2 to the power of the drop count.
- R5: With `red_mode` = 1 or 3, half an output LSB (2^(drop-1), or 0 when drop is 0) is added before the floor.
- R6: With `red_mode` = 2, the low drop-count bits of the dither register are added before the floor.
- R7: The dither register is 16 bits. Reset loads 0xACE1 into it. On each accepted sample it shifts left and takes bit15^bit13^bit12^bit10 into bit 0. A sample uses the value held before its own shift, and the register holds when `in_valid` is low.
- R8: In the bipolar formats, an input whose signed value is -2^(IN_W-1) is replaced by -(2^(IN_W-1)-1), and its `out_clip` is high.
- R9: Results outside ±(2^(OUT_W-1)-1) saturate to the nearer bound and raise `out_clip`. The code -2^(OUT_W-1) is never produced.
- R10: `out_valid` equals `in_valid` from two cycles earlier, and `out_data` and `out_clip` belong to that same sample. `out_clip` is low whenever `out_valid` is low.
- R11: A synchronous active-high `rst` clears both pipeline valid bits and reloads the dither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Raw sample word |
| in_fmt | input | 2 | Input coding: 0 offset binary, 1/3 two's complement, 2 unipolar |
| red_mode | input | 2 | Narrowing: 0 truncate, 1/3 round, 2 dither |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | OUT_W | Signed result |
| out_clip | output | 1 | Sample was clamped |

## Verification
The bench targets the most negative input code in both bipolar formats. A design that lets this code through emits a value one step below the symmetric range and leaves the flag low. It also drives full-scale positive inputs in round mode, where the half-LSB carry overflows. An unsaturated design wraps these to a large negative output.

Exact half-LSB ties at negative values are covered too. Here a truncating or sign-magnitude rounder comes out one step off. Dithered samples are sent with gaps in the valid stream, so a dither register that advances on idle cycles falls out of step with the reference sequence. Unipolar full scale checks the extra dropped bit, because a wrong shift count doubles or halves the output.

// File: rtl/adc_requant.sv
module adc_requant #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       in_fmt,
  input  logic [1:0]       red_mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_clip
);
  localparam int CW = IN_W + 2;
  localparam int SB = IN_W - OUT_W;
  localparam int SU = SB + 1;
  localparam int HB = (1 << SB) >> 1;
  localparam int HU = (1 << SU) >> 1;
  localparam int MB = (1 << SB) - 1;
  localparam int MU = (1 << SU) - 1;
  localparam logic signed [CW-1:0] PMAX = CW'((1 << (OUT_W-1)) - 1);
  localparam logic signed [CW-1:0] NMAX = -PMAX;

  logic [15:0] lfsr;
  logic signed [CW-1:0] conv, conv_c, addv, dmask, s1_sum, shifted;
  logic bip, is_min;
  logic s1_v, s1_uni, s1_clip;
  logic s2_v, s2_clip;
  logic [OUT_W-1:0] s2_data;

  always_comb begin
    case (in_fmt)
      2'd0:    conv = {{2{~in_data[IN_W-1]}}, ~in_data[IN_W-1], in_data[IN_W-2:0]};
      2'd2:    conv = {2'b00, in_data};
      default: conv = {{2{in_data[IN_W-1]}}, in_data};
    endcase
  end

  assign bip    = (in_fmt != 2'd2);
  assign is_min = bip && conv[IN_W-1] && (conv[IN_W-2:0] == '0);
  assign conv_c = is_min ? conv + CW'(1) : conv;
  assign dmask  = bip ? CW'(MB) : CW'(MU);

  always_comb begin
    case (red_mode)
      2'd0:    addv = '0;
      2'd2:    addv = CW'(lfsr) & dmask;
      default: addv = bip ? CW'(HB) : CW'(HU);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else if (in_valid) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s1_clip <= 1'b0;
    end else begin
      s1_v <= in_valid;
      s1_clip <= in_valid & is_min;
    end
    s1_sum <= conv_c + addv;
    s1_uni <= ~bip;
  end

  assign shifted = s1_uni ? (s1_sum >>> SU) : (s1_sum >>> SB);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0;
      s2_clip <= 1'b0;
    end else begin
      s2_v <= s1_v;
      s2_clip <= s1_v & (s1_clip | (shifted > PMAX) | (shifted < NMAX));
    end
    if (shifted > PMAX)      s2_data <= PMAX[OUT_W-1:0];
    else if (shifted < NMAX) s2_data <= NMAX[OUT_W-1:0];
    else                     s2_data <= shifted[OUT_W-1:0];
  end

  assign out_valid = s2_v;
  assign out_data  = s2_data;
  assign out_clip  = s2_clip;
endmodule

module adc_requant_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic [1:0]       in_fmt,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             out_clip,
  input logic [15:0]      lfsr
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));
  a_r10_clip_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_clip |-> out_valid);
  a_r9_no_min_code: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data != {1'b1, {(OUT_W-1){1'b0}}}));
  a_r8_min_in_clips: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_fmt != 2'd2 &&
     in_data == ((in_fmt == 2'd0) ? {IN_W{1'b0}} : {1'b1, {(IN_W-1){1'b0}}}))
    |=> ##1 out_clip);
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(lfsr));
  a_r7_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr != 16'd0);
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid || since_rst != 2'd0);
endmodule

bind adc_requant adc_requant_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_fmt(in_fmt),
  .out_valid(out_valid), .out_data(out_data), .out_clip(out_clip), .lfsr(lfsr)
);

// File: tb/adc_requant_tb.sv
module adc_requant_tb;
  localparam int CLK_P = 10;
  localparam int IN_W = 16;
  localparam int OUT_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [1:0] in_fmt = 2'd0, red_mode = 2'd0;
  logic out_valid, out_clip;
  logic [OUT_W-1:0] out_data;

  int n_tests = 0, n_fail = 0;
  logic [15:0] m_lfsr;
  logic p0_v, p1_v, p0_c, p1_c;
  longint p0_d, p1_d;
  string p0_t, p1_t;

  always #(CLK_P/2) clk = ~clk;

  adc_requant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_fmt(in_fmt),
    .red_mode(red_mode), .out_valid(out_valid), .out_data(out_data), .out_clip(out_clip)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [IN_W-1:0] d, input logic [1:0] f,
                                input logic [1:0] rm, input logic [15:0] r,
                                output longint o, output logic c, output string tag);
    longint v, a, mx;
    int drop;
    c = 1'b0;
    if (f == 2'd0)      begin v = longint'(d) - (64'sd1 <<< (IN_W-1)); tag = "R1"; end
    else if (f == 2'd2) begin v = longint'(d); tag = "R3"; end
    else                begin v = longint'($signed(d)); tag = "R2"; end
    if (f != 2'd2 && v == -(64'sd1 <<< (IN_W-1))) begin
      v = v + 1; c = 1'b1; tag = "R8";
    end
    drop = (f == 2'd2) ? IN_W + 1 - OUT_W : IN_W - OUT_W;
    if (rm == 2'd0)      a = 0;
    else if (rm == 2'd2) a = longint'(r) % (64'sd1 <<< drop);
    else                 a = (drop == 0) ? 0 : (64'sd1 <<< (drop - 1));
    if (!c) tag = (rm == 2'd0) ? {tag, "/R4"} : (rm == 2'd2) ? {tag, "/R6/R7"} : {tag, "/R5"};
    o = (v + a) >>> drop;
    mx = (64'sd1 <<< (OUT_W-1)) - 1;
    if (o > mx)  begin o = mx;  c = 1'b1; tag = {tag, "/R9"}; end
    if (o < -mx) begin o = -mx; c = 1'b1; tag = {tag, "/R9"}; end
  endfunction

  task automatic step(input logic v, input logic [IN_W-1:0] d, input logic [1:0] f,
                      input logic [1:0] rm);
    longint o; logic c; string tag;
    @(negedge clk);
    chk("R10 valid", longint'(out_valid), longint'(p1_v));
    if (p1_v) begin
      chk({p1_t, " data"}, longint'($signed(out_data)), p1_d);
      chk({p1_t, "/R10 clip"}, longint'(out_clip), longint'(p1_c));
    end else begin
      chk("R10 clip idle", longint'(out_clip), 0);
    end
    model(d, f, rm, m_lfsr, o, c, tag);
    if (v) m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    p1_v = p0_v; p1_d = p0_d; p1_c = p0_c; p1_t = p0_t;
    p0_v = v; p0_d = o; p0_c = c; p0_t = tag;
    in_valid = v; in_data = d; in_fmt = f; red_mode = rm;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R11 reset valid", longint'(out_valid), 0);
    @(negedge clk);
    chk("R11 reset valid", longint'(out_valid), 0);
    rst = 1'b0;
    m_lfsr = 16'hACE1;
    p0_v = 0; p1_v = 0; p0_c = 0; p1_c = 0; p0_d = 0; p1_d = 0; p0_t = ""; p1_t = "";
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    step(1, 16'h8000, 2'd0, 2'd0);
    step(1, 16'h0000, 2'd0, 2'd0);
    step(1, 16'hFFFF, 2'd0, 2'd0);
    step(1, 16'hFFFF, 2'd0, 2'd1);
    step(1, 16'h8000, 2'd1, 2'd1);
    step(1, 16'h8000, 2'd3, 2'd0);
    step(1, 16'h0008, 2'd1, 2'd1);
    step(1, 16'hFFF8, 2'd1, 2'd1);
    step(1, 16'hFFFF, 2'd1, 2'd0);
    step(1, 16'hFFFF, 2'd2, 2'd1);
    step(1, 16'hFFFF, 2'd2, 2'd0);
    step(1, 16'h0010, 2'd2, 2'd1);
    step(1, 16'h7FFF, 2'd1, 2'd3);
    step(0, 16'h1234, 2'd1, 2'd2);
    step(1, 16'h0007, 2'd1, 2'd2);
    step(0, 16'h0000, 2'd0, 2'd2);
    step(1, 16'h0007, 2'd1, 2'd2);
    for (int i = 0; i < 4000; i++) begin
      logic [IN_W-1:0] d;
      int k;
      k = $urandom % 10;
      d = (k == 0) ? 16'h8000 : (k == 1) ? 16'h0000 : (k == 2) ? 16'hFFFF :
          (k == 3) ? 16'h7FFF : IN_W'($urandom);
      step(($urandom % 5) != 0, d, 2'($urandom), 2'($urandom));
      if (i == 2000) begin
        step(1, 16'h4000, 2'd0, 2'd2);
        do_reset();
      end
    end
    step(0, 16'h0000, 2'd0, 2'd0);
    step(0, 16'h0000, 2'd0, 2'd0);
    step(0, 16'h0000, 2'd0, 2'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule